// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

An eight-pin (parameterised) general-purpose I/O port sitting between a CPU register interface and a row of pad cells. The CPU writes a data latch, a direction mask, a pull-up mask and an analog-disable mask through a two-bit address. The port turns these into per-pin output-enable, output-value and pull-up-enable signals. Each pad's input level is sampled and passed both to on-chip peripherals and to CPU reads.

A peripheral output function, for example a display segment driver, can claim any pin through a per-pin override. When it does, its value and drive replace the latch and direction bit for that pin. Two conditions change read and pin behaviour. A read marked as part of a read-modify-write instruction returns the latch instead of the pin levels. A low-power standby state, when combined with the pin-hold control, floats every pin and clamps its input path low so open pads cannot leak.

Top module: `gpio_port`

## Requirements
- R1: After reset the data latch, direction mask and pull-up mask are all zero, the analog-disable mask is all ones, and pad_oe_o, pad_pu_o, pin_in_o and ana_en_o are all zero.
- R2: A cycle with wr_en_i high stores wdata_i into the register chosen by addr_i: 0 data latch, 1 direction mask, 2 pull-up mask, 3 analog-disable mask. Reads of addresses 1 to 3 return the stored value from the cycle after the write. Writes to the data latch are kept even while every pin is an input.
- R3: A read of address 0 with rmw_i low returns the pin levels sampled at the previous clock edge.
- R4: A read of address 0 with rmw_i high returns the data latch.
- R5: With no override and no forced standby, pad_oe_o equals the direction mask and pad_out_o equals the data latch, one clock after the registers hold those values. A direction bit of 1 means output.
- R6: Outside forced standby, a pin whose per_oe_i bit is 1 has pad_oe_o at 1 and pad_out_o equal to its per_out_i bit, whatever its latch and direction bits hold.
- R7: pad_pu_o of a pin is its pull-up bit, except that it is 0 whenever that pin drives a low level.
- R8: When stby_i and pin_hold_i are both 1, every pad_oe_o bit is 0 one clock later, regardless of the direction mask and the overrides.
- R9: In that forced standby condition, pin_in_o and the pin-level read of address 0 are all zero one clock later, whatever pad_in_i carries.
- R10: With stby_i at 1 and pin_hold_i at 0, the pad outputs keep the values they had before standby.
- R11: ana_en_o of a pin is the inverse of its analog-disable bit, independent of the data latch, the direction mask and standby.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rmw_i | input | 1 | Current read belongs to a read-modify-write instruction |
| rdata_o | output | 8 | Combinational read data for addr_i |
| stby_i | input | 1 | Device is in a stop or watch low-power state |
| pin_hold_i | input | 1 | Pin-state control: 1 floats and clamps pins in standby |
| per_oe_i | input | 8 | Per-pin peripheral output claim |
| per_out_i | input | 8 | Per-pin peripheral output value |
| pad_in_i | input | 8 | Pad input levels |
| pad_oe_o | output | 8 | Pad output enables, registered |
| pad_out_o | output | 8 | Pad output values, registered |
| pad_pu_o | output | 8 | Pad pull-up enables, registered |
| pin_in_o | output | 8 | Sampled, clamp-gated pin levels for peripherals |
| ana_en_o | output | 8 | Analog input enables toward the comparator |

## Verification
A register write is captured at the first clock edge and reaches the pad outputs at the second, so the bench holds every stimulus across two edges and compares pad_oe_o, pad_out_o, pad_pu_o and ana_en_o only after the second. Pin sampling and the standby clamp take one edge, and the bench samples pin_in_o and the pin-level read after that edge. Register read-back is combinational once the write edge has passed, so the bench changes addr_i and rmw_i between edges and compares rdata_o a nanosecond later. All sampling happens at the falling clock edge, away from the edge where the design updates.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_PULL = 2'd2,
    REG_ANAD = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  dat_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  pul_o,
  output logic [WIDTH-1:0]  anad_o
);
  localparam logic [WIDTH-1:0] ANAD_RST = {WIDTH{1'b1}};

  logic [WIDTH-1:0] dat_q, dir_q, pul_q, anad_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dat_q  <= '0;
      dir_q  <= '0;
      pul_q  <= '0;
      anad_q <= ANAD_RST;
    end else if (wr_en_i) begin
      case (gpio_reg_e'(addr_i))
        REG_DATA: dat_q  <= wdata_i;
        REG_DIR:  dir_q  <= wdata_i;
        REG_PULL: pul_q  <= wdata_i;
        default:  anad_q <= wdata_i;
      endcase
    end
  end

  assign dat_o  = dat_q;
  assign dir_o  = dir_q;
  assign pul_o  = pul_q;
  assign anad_o = anad_q;

  AST_DIR_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (dir_q == '0 && anad_q == ANAD_RST)); // R1
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && $past(wr_en_i) && $past(addr_i) == REG_DIR) |-> (dir_q == $past(wdata_i))); // R2
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             force_i,
  input  logic [WIDTH-1:0] dat_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] pul_i,
  input  logic [WIDTH-1:0] anad_i,
  input  logic [WIDTH-1:0] per_oe_i,
  input  logic [WIDTH-1:0] per_out_i,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] pu_o,
  output logic [WIDTH-1:0] in_o,
  output logic [WIDTH-1:0] ana_o
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_pin
    logic drv_en, drv_val;
    logic oe_r, out_r, pu_r, in_r, ana_r;

    assign drv_en  = force_i ? 1'b0 : (per_oe_i[k] | dir_i[k]);
    assign drv_val = per_oe_i[k] ? per_out_i[k] : dat_i[k];

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        oe_r  <= 1'b0;
        out_r <= 1'b0;
        pu_r  <= 1'b0;
        in_r  <= 1'b0;
        ana_r <= 1'b0;
      end else begin
        oe_r  <= drv_en;
        out_r <= drv_val;
        pu_r  <= pul_i[k] & ~(drv_en & ~drv_val);
        in_r  <= ~force_i & pad_in_i[k];
        ana_r <= ~anad_i[k];
      end
    end

    assign oe_o[k]  = oe_r;
    assign out_o[k] = out_r;
    assign pu_o[k]  = pu_r;
    assign in_o[k]  = in_r;
    assign ana_o[k] = ana_r;
  end

  AST_FORCE_HIZ: assert property (@(posedge clk_i) disable iff (rst_i)
    force_i |=> (oe_o == '0)); // R8
  AST_FORCE_CLAMP: assert property (@(posedge clk_i) disable iff (rst_i)
    force_i |=> (in_o == '0)); // R9
  AST_PULL_OFF_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    ((pu_o & oe_o & ~out_o) == '0)); // R7
  AST_OVR_DRIVES: assert property (@(posedge clk_i) disable iff (rst_i)
    !force_i |=> ((oe_o & $past(per_oe_i)) == $past(per_oe_i))); // R6
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rmw_i,
  input  logic [WIDTH-1:0]  dat_i,
  input  logic [WIDTH-1:0]  dir_i,
  input  logic [WIDTH-1:0]  pul_i,
  input  logic [WIDTH-1:0]  anad_i,
  input  logic [WIDTH-1:0]  pins_i,
  output logic [WIDTH-1:0]  rdata_o
);
  always_comb begin
    case (gpio_reg_e'(addr_i))
      REG_DATA: rdata_o = rmw_i ? dat_i : pins_i;
      REG_DIR:  rdata_o = dir_i;
      REG_PULL: rdata_o = pul_i;
      default:  rdata_o = anad_i;
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              rmw_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic              stby_i,
  input  logic              pin_hold_i,
  input  logic [WIDTH-1:0]  per_oe_i,
  input  logic [WIDTH-1:0]  per_out_i,
  input  logic [WIDTH-1:0]  pad_in_i,
  output logic [WIDTH-1:0]  pad_oe_o,
  output logic [WIDTH-1:0]  pad_out_o,
  output logic [WIDTH-1:0]  pad_pu_o,
  output logic [WIDTH-1:0]  pin_in_o,
  output logic [WIDTH-1:0]  ana_en_o
);
  logic [WIDTH-1:0] dat, dir, pul, anad;
  logic             force_hiz;

  assign force_hiz = stby_i & pin_hold_i;

  gpio_regs #(.WIDTH(WIDTH)) regs_i (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .dat_o(dat), .dir_o(dir), .pul_o(pul), .anad_o(anad)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH)) pads_i (
    .clk_i(clk_i), .rst_i(rst_i), .force_i(force_hiz),
    .dat_i(dat), .dir_i(dir), .pul_i(pul), .anad_i(anad),
    .per_oe_i(per_oe_i), .per_out_i(per_out_i), .pad_in_i(pad_in_i),
    .oe_o(pad_oe_o), .out_o(pad_out_o), .pu_o(pad_pu_o),
    .in_o(pin_in_o), .ana_o(ana_en_o)
  );

  gpio_rd_mux #(.WIDTH(WIDTH)) rdmux_i (
    .addr_i(addr_i), .rmw_i(rmw_i), .dat_i(dat), .dir_i(dir),
    .pul_i(pul), .anad_i(anad), .pins_i(pin_in_o), .rdata_o(rdata_o)
  );

  AST_RMW_LATCH: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && $past(wr_en_i) && $past(addr_i) == REG_DATA && !wr_en_i
     && addr_i == REG_DATA && rmw_i) |-> (rdata_o == $past(wdata_i))); // R4
endmodule

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         wr_en, rmw, stby, hold;
  logic [1:0]   addr;
  logic [W-1:0] wdata, per_oe, per_out, pad_in;
  logic [W-1:0] rdata, pad_oe, pad_out, pad_pu, pin_in, ana_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [W-1:0] m_dat, m_dir, m_pul, m_anad;

  always #10 clk = ~clk;

  gpio_port #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rmw_i(rmw), .rdata_o(rdata), .stby_i(stby), .pin_hold_i(hold),
    .per_oe_i(per_oe), .per_out_i(per_out), .pad_in_i(pad_in),
    .pad_oe_o(pad_oe), .pad_out_o(pad_out), .pad_pu_o(pad_pu),
    .pin_in_o(pin_in), .ana_en_o(ana_en)
  );

  function automatic logic [W-1:0] f_oe();
    return (stby && hold) ? '0 : (per_oe | m_dir);
  endfunction
  function automatic logic [W-1:0] f_out();
    return (per_oe & per_out) | (~per_oe & m_dat);
  endfunction
  function automatic logic [W-1:0] f_pu();
    return m_pul & ~(f_oe() & ~f_out());
  endfunction
  function automatic logic [W-1:0] f_pin();
    return (stby && hold) ? '0 : pad_in;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      2'd0: m_dat = d;
      2'd1: m_dir = d;
      2'd2: m_pul = d;
      default: m_anad = d;
    endcase
  endtask

  task automatic check_pads(input string tag);
    chk({tag, " R5/R6/R8 oe"}, pad_oe, f_oe());
    chk({tag, " R5/R6 out"}, pad_out, f_out());
    chk({tag, " R7 pull"}, pad_pu, f_pu());
    chk({tag, " R9 pin_in"}, pin_in, f_pin());
    chk({tag, " R11 ana"}, ana_en, ~m_anad);
  endtask

  task automatic check_reads(input string tag);
    rmw = 1'b0; addr = 2'd0; #1; chk({tag, " R3 pin read"}, rdata, f_pin());
    rmw = 1'b1; #1; chk({tag, " R4 rmw read"}, rdata, m_dat);
    rmw = 1'b0; addr = 2'd1; #1; chk({tag, " R2 dir read"}, rdata, m_dir);
    addr = 2'd2; #1; chk({tag, " R2 pull read"}, rdata, m_pul);
    addr = 2'd3; #1; chk({tag, " R2 anad read"}, rdata, m_anad);
    addr = 2'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] s_oe, s_out, s_pu;
    void'($urandom(32'd1234));
    rst = 1'b1; wr_en = 1'b0; rmw = 1'b0; addr = '0; wdata = '0;
    stby = 1'b0; hold = 1'b0; per_oe = '0; per_out = '0; pad_in = '0;
    m_dat = '0; m_dir = '0; m_pul = '0; m_anad = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 oe", pad_oe, '0);
    chk("R1 pull", pad_pu, '0);
    chk("R1 pin_in", pin_in, '0);
    chk("R1 ana", ana_en, '0);
    check_reads("R1");

    // R2 data write accepted while all pins inputs
    pad_in = 8'h3C;
    write_reg(2'd0, 8'hA5);
    @(negedge clk);
    check_pads("R2 inputs");
    check_reads("R2 inputs");

    // R5 plain output, R7 pull drop on low pins
    write_reg(2'd2, 8'hFF);
    write_reg(2'd1, 8'hF0);
    @(negedge clk);
    check_pads("R5 drive");
    chk("R7 directed pull", pad_pu, 8'hAF);

    // R6 override
    per_oe = 8'h0F; per_out = 8'h06;
    @(negedge clk); @(negedge clk);
    check_pads("R6 override");
    chk("R6 directed oe", pad_oe, 8'hFF);

    // R10 standby without hold keeps outputs
    s_oe = pad_oe; s_out = pad_out; s_pu = pad_pu;
    stby = 1'b1; hold = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 oe kept", pad_oe, s_oe);
    chk("R10 out kept", pad_out, s_out);
    chk("R10 pull kept", pad_pu, s_pu);

    // R8/R9 forced standby
    hold = 1'b1; pad_in = 8'hFF;
    @(negedge clk);
    chk("R8 forced oe", pad_oe, '0);
    chk("R9 forced pin_in", pin_in, '0);
    check_reads("R9 forced");
    stby = 1'b0; hold = 1'b0; per_oe = '0;

    // R11 analog independence
    write_reg(2'd3, 8'h5A);
    write_reg(2'd1, 8'h00);
    @(negedge clk);
    chk("R11 directed ana", ana_en, 8'hA5);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 3));
      per_oe  = W'($urandom);
      per_oe  = per_oe & W'($urandom);
      per_out = W'($urandom);
      pad_in  = W'($urandom);
      stby    = ($urandom_range(0, 3) == 0);
      hold    = 1'($urandom);
      write_reg(a, W'($urandom));
      @(negedge clk);
      check_pads("rand");
      check_reads("rand");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule